// File: doc/BRIEF.md
# Cache Line Fill Bus Sequencer

This block fetches one cache line from a DRAM. It uses a memory bus that is one word wide and clocked, and the DRAM has a fixed access latency. The cache hands the sequencer a block address through a valid/ready request port. The sequencer then drives a single address cycle on the bus. For each word of the line it waits out the full DRAM access time and then takes the word from the bus in one transfer cycle. Each word goes straight on to the cache with its index within the line, and a one-cycle done pulse closes the fill.

The block runs on the bus clock. Every delay it produces is a count of bus cycles, so the bus clock can be slower than the processor clock. The access latency and the line length are parameters, with defaults of 15 cycles and 4 words. With the defaults a fill occupies 1 + 4×15 + 4×1 = 65 bus cycles.

The request port follows valid/ready rules. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A requester may hold `req_valid` high and wait. The word output has no back-pressure: the DRAM timing is fixed, so the cache must take every word in the cycle in which `word_valid` is high.

Top module: `line_fill_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `word_valid` and `bus_addr_valid` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when the block is idle. A request offered while a fill or its done cycle is in progress is dropped: it does not change the address, the timing or the strobes, and no second fill follows it.
- R3: In the cycle after a request is accepted, `bus_addr_valid` is 1 for exactly that one cycle, and `bus_addr` holds the accepted block address.
- R4: After the address cycle, each word gets ACCESS_CYC cycles with no strobe, followed by one cycle with `word_valid` 1. With the address cycle counted as cycle 1, word i is transferred in cycle 1 + (i+1)×(ACCESS_CYC+1).
- R5: In each transfer cycle, `word_data` equals `bus_data` in that same cycle, and `word_idx` runs 0, 1, … LINE_WORDS-1 in ascending order.
- R6: The span from the address cycle through the last transfer is 1 + LINE_WORDS×(ACCESS_CYC+1) cycles, which is 65 with the defaults.
- R7: `done` is 1 for exactly one cycle, the cycle after the last transfer. `busy` is 1 from the address cycle through the done cycle.
- R8: A new request can be accepted in the cycle right after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Line-fill request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | ADDR_W | Block address of the line |
| bus_addr_valid | output | 1 | Address cycle strobe on the memory bus |
| bus_addr | output | ADDR_W | Block address driven to the memory |
| bus_data | input | DATA_W | Word returned by the memory bus |
| word_valid | output | 1 | A line word is delivered this cycle |
| word_idx | output | IDX_W | Index of the delivered word within the line |
| word_data | output | DATA_W | Delivered word |
| busy | output | 1 | Fill in progress, done cycle included |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The cycle after a request is taken is counted as cycle 1. The address strobe is due in cycle 1, word i in cycle 1 + (i+1)×(ACCESS_CYC+1), and done one cycle after the last word. The bench keeps a cycle index for each fill and samples every output at the falling edge of every cycle up to the done cycle. Each sample is compared with values the bench works out from that index, so a strobe arriving one cycle early or late is caught in the cycle where it differs. The span is measured from the observed address strobe to the observed last word. Requests that should be dropped are offered in the middle of a fill and in the done cycle, and the bench checks the cycle after each fill for the absence of an address strobe.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ADDR,
    FS_WAIT,
    FS_XFER,
    FS_DONE
  } fill_state_e;
endpackage

// File: rtl/access_timer.sv
module access_timer #(
  parameter int ACCESS_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CNT_W'(ACCESS_CYC - 1);
    else if (run && cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign expire = run && (cnt == '0);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> run);
endmodule

// File: rtl/word_tracker.sv
module word_tracker #(
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (clr)
      idx <= '0;
    else if (step && !last)
      idx <= idx + IDX_W'(1);
  end

  assign last = (idx == IDX_W'(LINE_WORDS - 1));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !clr) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        wait_expire,
  input  logic        last_word,
  output fill_state_e state
);
  fill_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      FS_IDLE: if (req_fire) nxt = FS_ADDR;
      FS_ADDR: nxt = FS_WAIT;
      FS_WAIT: if (wait_expire) nxt = FS_XFER;
      FS_XFER: nxt = last_word ? FS_DONE : FS_WAIT;
      FS_DONE: nxt = FS_IDLE;
      default: nxt = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FS_IDLE;
    else        state <= nxt;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_DONE) |=> (state == FS_IDLE));

  // R4
  xfer_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_XFER) |=> (state != FS_XFER));
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import fill_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ACCESS_CYC = 15,
  localparam int IDX_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              bus_addr_valid,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              word_valid,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic              busy,
  output logic              done
);
  fill_state_e       state;
  logic              req_fire;
  logic              expire;
  logic              last_word;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = (state == FS_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (req_fire) addr_q <= req_addr;
  end

  fill_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .wait_expire (expire),
    .last_word   (last_word),
    .state       (state)
  );

  access_timer #(.ACCESS_CYC(ACCESS_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  ((state == FS_ADDR) || (state == FS_XFER && !last_word)),
    .run    (state == FS_WAIT),
    .expire (expire)
  );

  word_tracker #(.LINE_WORDS(LINE_WORDS)) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (req_fire),
    .step  (state == FS_XFER),
    .idx   (word_idx),
    .last  (last_word)
  );

  assign bus_addr_valid = (state == FS_ADDR);
  assign bus_addr       = addr_q;
  assign word_valid     = (state == FS_XFER);
  assign word_data      = bus_data;
  assign busy           = (state != FS_IDLE);
  assign done           = (state == FS_DONE);

  // R3
  addr_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (bus_addr_valid && bus_addr == $past(req_addr)));

  // R2
  addr_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bus_addr));

  // R4
  no_word_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_valid |=> !word_valid);
endmodule

// File: tb/line_fill_seq_bench.sv
module line_fill_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int W      = 4;
  localparam int L      = 15;
  localparam int IDX_W  = 2;
  localparam int SPAN   = 1 + W * (L + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              bus_addr_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic              word_valid;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] word_data;
  logic              busy;
  logic              done;

  int gcyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) gcyc <= gcyc + 1;
  assign bus_data = DATA_W'(32'h5A00_0000 + gcyc);

  line_fill_seq u_line_fill_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .word_valid(word_valid), .word_idx(word_idx),
    .word_data(word_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(busy == 1'b0, {tag, " busy"}, 64'(busy), 0);
    chk(req_ready == 1'b1, {tag, " req_ready"}, 64'(req_ready), 1);
    chk(done == 1'b0, {tag, " done"}, 64'(done), 0);
    chk(word_valid == 1'b0, {tag, " word_valid"}, 64'(word_valid), 0);
    chk(bus_addr_valid == 1'b0, {tag, " bus_addr_valid"}, 64'(bus_addr_valid), 0);
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a, input bit poke, input bit late_req);
    int first_a;
    int last_w;
    first_a = -1;
    last_w = -1;
    @(negedge clk);
    // R8: offered right after the previous done cycle, must be taken
    chk(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    for (int k = 1; k <= SPAN + 1; k++) begin
      bit xfer;
      int wi;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke && k == 10) begin req_valid = 1'b1; req_addr = ~a; end
      if (late_req && k == SPAN + 1) begin req_valid = 1'b1; req_addr = ~a; end
      xfer = (k > 1) && ((k - 1) % (L + 1) == 0);
      wi   = (k - 1) / (L + 1) - 1;
      chk(bus_addr_valid == (k == 1), "R3 address strobe", 64'(bus_addr_valid), 64'(k == 1));
      if (k == 1) chk(bus_addr == a, "R3 address value", 64'(bus_addr), 64'(a));
      chk(word_valid == xfer, "R4 transfer strobe", 64'(word_valid), 64'(xfer));
      if (xfer && word_valid) begin
        chk(word_idx == IDX_W'(wi), "R5 word index", 64'(word_idx), 64'(wi));
        chk(word_data == DATA_W'(32'h5A00_0000 + gcyc), "R5 word data",
            64'(word_data), 64'(DATA_W'(32'h5A00_0000 + gcyc)));
      end
      chk(done == (k == SPAN + 1), "R7 done pulse", 64'(done), 64'(k == SPAN + 1));
      chk(busy == 1'b1, "R7 busy", 64'(busy), 1);
      chk(req_ready == 1'b0, "R2 ready low while busy", 64'(req_ready), 0);
      if (bus_addr_valid) first_a = k;
      if (word_valid) last_w = k;
    end
    chk(last_w - first_a + 1 == SPAN, "R6 fill span", 64'(last_w - first_a + 1), 64'(SPAN));
    if (late_req) begin
      @(negedge clk);
      req_valid = 1'b0;
      idle_chk("R2 request in done cycle dropped");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 after reset");
    do_fill(26'h000_0000, 1'b0, 1'b0);
    do_fill(26'h3FF_FFFF, 1'b1, 1'b0);
    do_fill(26'h2AA_AAAA, 1'b0, 1'b1);
    do_fill(26'h123_4567, 1'b1, 1'b1);
    do_fill(26'h000_0001, 1'b1, 1'b0);
    @(negedge clk);
    idle_chk("R2 no extra fill from dropped request");
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule